// File: doc/BRIEF.md
# Shadowed Persistent Control Register Bank

This block keeps six byte-wide control registers at addresses 0 to 5. The four middle registers (addresses 1 to 4) each hold two copies: a working copy that drives the configuration outputs, and a persistent backing copy that is not cleared by the warm reset. Registers 0 and 5 are plain single-copy registers. Bit 7 of register 0 is the persist-select bit. When it is set, writes to the middle registers go to both copies. When it is clear, they change only the working copy.

A single-cycle byte port accesses the bank. It has an address, write data, a write strobe and a read strobe. A read of a middle register always returns the backing copy. A power-up pulse, once released, reloads every working copy from its backing copy. A write to register 0 or 5 while persist-select is clear does the same reload. An active-low write-protect input blocks every write and every write-triggered reload. The backing copy is modelled with ordinary flip-flops that have no reset. The serial bus front end and real cell timing are outside this block.

Top module: `shadow_ctrl_bank`

## Requirements
- R1: While `rstN` is low, `ctrl0Out`, `ctrl5Out`, `cfgVol` and `rdData` are all zero. The backing copies keep their contents.
- R2: A power-up release reloads all four working copies from their backing copies. A release is the first rising clock edge at which `pwrUp` is sampled low after it was sampled high on the previous edge. The result is visible after that edge.
- R3: With bit 7 of register 0 at 1, an accepted write to address 1 to 4 updates both the working and the backing copy of that register.
- R4: With bit 7 of register 0 at 0, an accepted write to address 1 to 4 updates only the working copy. Later reads return the old backing value, and the next reload restores it.
- R5: An accepted write to address 0 or 5 reloads all working copies from the backing copies. This happens only when bit 7 of register 0 was 0 before that write.
- R6: While `wrProtN` is low, writes to every address are ignored and no write-triggered reload occurs.
- R7: A read takes its value at the edge where `rdEn` is sampled high. Addresses 1 to 4 return the backing copy, and addresses 0 and 5 return their stored value. `rdData` holds when `rdEn` is low.
- R8: Writes to addresses 6 and 7 are ignored, and reads of those addresses return 0x00.
- R9: When a power-up release and an accepted write to address 1 to 4 fall on the same edge, the addressed working copy takes the write data. The others are reloaded.
- R10: `ctrl0Out` and `ctrl5Out` show registers 0 and 5. `cfgVol` bits [8k-1:8(k-1)] show the working copy of address k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low warm reset; backing copies are not cleared |
| pwrUp | input | 1 | Power-up pulse; its release triggers a reload |
| wrProtN | input | 1 | Active-low write protect |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| ctrl0Out | output | 8 | Register 0 contents |
| ctrl5Out | output | 8 | Register 5 contents |
| cfgVol | output | 32 | Working copies of addresses 1 to 4, packed |

## Verification
Every result of this block appears exactly one rising edge after the inputs that caused it are sampled. This covers a write, a read, a write-triggered reload and a power-up release, with no extra latency on any path. The bench drives each stimulus at a falling edge and runs a reference model of the register state before the next rising edge. It compares every output at the following falling edge, so each comparison lands one edge after its stimulus. Backing copies start in an unknown state, so the model tracks which bytes are known and compares only those.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_LOW,
    RD_SHADOW,
    RD_HIGH
  } rdSel_e;

  typedef struct packed {
    logic             recall;
    logic             wrVol;
    logic             wrNv;
    logic             wrLow;
    logic             wrHigh;
    logic             rdLatch;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] idx;
  } bankStb_t;

endpackage

// File: rtl/shadow_cell.sv
module shadow_cell #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrVol,
  input  logic              wrNv,
  input  logic              recall,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] volQ,
  output logic [DATA_W-1:0] nvQ
);

  // Backing copy: no reset, it survives the warm reset
  always_ff @(posedge clk) begin
    if (wrNv) nvQ <= wrData;
  end

  // Working copy: a direct write wins over a reload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       volQ <= '0;
    else if (wrVol)  volQ <= wrData;
    else if (recall) volQ <= nvQ;
  end

endmodule

// File: rtl/shadow_bank_ctrl.sv
module shadow_bank_ctrl
  import shadow_bank_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int SHADOW_CNT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrUp,
  input  logic              wrProtN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              persistNow,
  input  logic [ADDR_W-1:0] addr,
  output bankStb_t          stb
);

  localparam int HIGH_IDX = SHADOW_CNT + 1;
  localparam logic [ADDR_W-1:0] HIGH_ADDR = ADDR_W'(HIGH_IDX);

  logic pwrUpQ;
  logic pwrRel;
  logic isLow;
  logic isHigh;
  logic isShadow;
  logic inRange;
  logic wrOk;
  logic recallWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwrUpQ <= 1'b0;
    else       pwrUpQ <= pwrUp;
  end

  assign pwrRel = pwrUpQ & ~pwrUp;

  always_comb begin
    isLow    = (addr == '0);
    isHigh   = (addr == HIGH_ADDR);
    isShadow = !isLow && (addr < HIGH_ADDR);
    inRange  = (addr <= HIGH_ADDR);
    wrOk     = wrEn & wrProtN & inRange;
    // the reload decision uses the persist bit held before this write lands
    recallWr = wrOk & (isLow | isHigh) & ~persistNow;
  end

  always_comb begin
    stb         = '0;
    stb.wrVol   = wrOk & isShadow;
    stb.wrNv    = wrOk & isShadow & persistNow;
    stb.wrLow   = wrOk & isLow;
    stb.wrHigh  = wrOk & isHigh;
    stb.recall  = recallWr | pwrRel;
    stb.rdLatch = rdEn;
    stb.idx     = IDX_W'(addr);
    if (isLow)         stb.rdSel = RD_LOW;
    else if (isShadow) stb.rdSel = RD_SHADOW;
    else if (isHigh)   stb.rdSel = RD_HIGH;
    else               stb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/shadow_bank_dp.sv
module shadow_bank_dp
  import shadow_bank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SHADOW_CNT = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  bankStb_t                     stb,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  output logic [DATA_W-1:0]            lowQ,
  output logic [DATA_W-1:0]            highQ,
  output logic [SHADOW_CNT*DATA_W-1:0] volFlat,
  output logic [SHADOW_CNT*DATA_W-1:0] nvFlat
);

  logic [DATA_W-1:0] shadowRd;
  logic [DATA_W-1:0] rdNext;

  for (genvar k = 0; k < SHADOW_CNT; k++) begin : gCell
    logic hit;
    assign hit = (stb.idx == IDX_W'(k + 1));
    shadow_cell #(.DATA_W(DATA_W)) uCell (
      .clk    (clk),
      .rstN   (rstN),
      .wrVol  (stb.wrVol & hit),
      .wrNv   (stb.wrNv & hit),
      .recall (stb.recall),
      .wrData (wrData),
      .volQ   (volFlat[k*DATA_W +: DATA_W]),
      .nvQ    (nvFlat[k*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowQ  <= '0;
      highQ <= '0;
    end else begin
      if (stb.wrLow)  lowQ  <= wrData;
      if (stb.wrHigh) highQ <= wrData;
    end
  end

  always_comb begin
    shadowRd = '0;
    for (int k = 0; k < SHADOW_CNT; k++) begin
      if (stb.idx == IDX_W'(k + 1)) shadowRd = nvFlat[k*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_LOW:    rdNext = lowQ;
      RD_SHADOW: rdNext = shadowRd;
      RD_HIGH:   rdNext = highQ;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (stb.rdLatch) rdData <= rdNext;
  end

endmodule

// File: rtl/shadow_ctrl_bank.sv
module shadow_ctrl_bank
  import shadow_bank_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SHADOW_CNT  = 4,
  parameter int PERSIST_BIT = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         pwrUp,
  input  logic                         wrProtN,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         wrEn,
  input  logic                         rdEn,
  output logic [DATA_W-1:0]            rdData,
  output logic [DATA_W-1:0]            ctrl0Out,
  output logic [DATA_W-1:0]            ctrl5Out,
  output logic [SHADOW_CNT*DATA_W-1:0] cfgVol
);

  bankStb_t                     stb;
  logic [SHADOW_CNT*DATA_W-1:0] nvFlat;

  shadow_bank_ctrl #(
    .ADDR_W     (ADDR_W),
    .SHADOW_CNT (SHADOW_CNT)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .pwrUp      (pwrUp),
    .wrProtN    (wrProtN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .persistNow (ctrl0Out[PERSIST_BIT]),
    .addr       (addr),
    .stb        (stb)
  );

  shadow_bank_dp #(
    .DATA_W     (DATA_W),
    .SHADOW_CNT (SHADOW_CNT)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .rdData  (rdData),
    .lowQ    (ctrl0Out),
    .highQ   (ctrl5Out),
    .volFlat (cfgVol),
    .nvFlat  (nvFlat)
  );

endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SHADOW_CNT  = 4,
  parameter int PERSIST_BIT = 7
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         pwrUp,
  input logic                         wrProtN,
  input logic [ADDR_W-1:0]            addr,
  input logic [DATA_W-1:0]            wrData,
  input logic                         wrEn,
  input logic                         rdEn,
  input logic [DATA_W-1:0]            rdData,
  input logic [DATA_W-1:0]            ctrl0Out,
  input logic [DATA_W-1:0]            ctrl5Out,
  input logic [SHADOW_CNT*DATA_W-1:0] cfgVol,
  input logic [SHADOW_CNT*DATA_W-1:0] nvFlat
);

  localparam logic [ADDR_W-1:0] HIGH_ADDR = ADDR_W'(SHADOW_CNT + 1);

  logic pwrPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwrPrev <= 1'b0;
    else       pwrPrev <= pwrUp;
  end

  for (genvar k = 1; k <= SHADOW_CNT; k++) begin : gShadow
    AST_VOL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrProtN && addr == ADDR_W'(k)) |=>
        cfgVol[(k-1)*DATA_W +: DATA_W] == $past(wrData)); // R9
    AST_NV_PERSIST: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrProtN && addr == ADDR_W'(k) && ctrl0Out[PERSIST_BIT]) |=>
        nvFlat[(k-1)*DATA_W +: DATA_W] == $past(wrData)); // R3
  end

  AST_NV_VOLATILE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl0Out[PERSIST_BIT] |=> $stable(nvFlat)); // R4

  AST_RECALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrProtN && (addr == '0 || addr == HIGH_ADDR) && !ctrl0Out[PERSIST_BIT])
      |=> cfgVol == $past(nvFlat)); // R5

  AST_PWR_RECALL: assert property (@(posedge clk) disable iff (!rstN)
    (pwrPrev && !pwrUp && !wrEn) |=> cfgVol == $past(nvFlat)); // R2

  AST_WP_REGS: assert property (@(posedge clk) disable iff (!rstN)
    !wrProtN |=> ($stable(ctrl0Out) && $stable(ctrl5Out))); // R6

  AST_WP_BACKING: assert property (@(posedge clk) disable iff (!rstN)
    !wrProtN |=> $stable(nvFlat)); // R6

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R7

  AST_RD_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr > HIGH_ADDR) |=> rdData == '0); // R8

endmodule

bind shadow_ctrl_bank shadow_bank_chk #(
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .SHADOW_CNT  (SHADOW_CNT),
  .PERSIST_BIT (PERSIST_BIT)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .pwrUp    (pwrUp),
  .wrProtN  (wrProtN),
  .addr     (addr),
  .wrData   (wrData),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .rdData   (rdData),
  .ctrl0Out (ctrl0Out),
  .ctrl5Out (ctrl5Out),
  .cfgVol   (cfgVol),
  .nvFlat   (nvFlat)
);

// File: tb/tb_shadow_ctrl_bank.sv
`timescale 1ns/1ps
module tb_shadow_ctrl_bank;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pwrUp;
  logic        wrProtN;
  logic [2:0]  addr;
  logic [7:0]  wrData;
  logic        wrEn;
  logic        rdEn;
  logic [7:0]  rdData;
  logic [7:0]  ctrl0Out;
  logic [7:0]  ctrl5Out;
  logic [31:0] cfgVol;

  int nChecks = 0;
  int nErr    = 0;

  // reference state
  logic [7:0] mVol [1:4];
  logic [7:0] mNv  [1:4];
  bit         kVol [1:4];
  bit         kNv  [1:4];
  logic [7:0] mR0, mR5, mRd;
  bit         kRd;
  bit         mPwrQ;

  always #4 clk = ~clk;

  shadow_ctrl_bank dut (
    .clk(clk), .rstN(rstN), .pwrUp(pwrUp), .wrProtN(wrProtN), .addr(addr),
    .wrData(wrData), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
    .ctrl0Out(ctrl0Out), .ctrl5Out(ctrl5Out), .cfgVol(cfgVol)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk("R10", "ctrl0Out", {24'd0, ctrl0Out}, {24'd0, mR0});
    chk("R10", "ctrl5Out", {24'd0, ctrl5Out}, {24'd0, mR5});
    if (kRd) chk("R7", "rdData", {24'd0, rdData}, {24'd0, mRd});
    for (int i = 1; i <= 4; i++) begin
      if (kVol[i]) chk(tag, $sformatf("cfgVol[%0d]", i),
                       {24'd0, cfgVol[(i-1)*8 +: 8]}, {24'd0, mVol[i]});
    end
  endtask

  task automatic step(input bit w, input bit r, input bit p, input bit wp,
                      input int a, input logic [7:0] d, input string tag);
    bit persistNow, ok, recall;
    wrEn = w; rdEn = r; pwrUp = p; wrProtN = wp; addr = 3'(a); wrData = d;
    persistNow = mR0[7];
    ok     = w && wp && a <= 5;
    recall = (mPwrQ && !p) || (ok && (a == 0 || a == 5) && !persistNow);
    if (r) begin
      if (a == 0)      begin mRd = mR0;   kRd = 1; end
      else if (a <= 4) begin mRd = mNv[a]; kRd = kNv[a]; end
      else if (a == 5) begin mRd = mR5;   kRd = 1; end
      else             begin mRd = 8'h00; kRd = 1; end
    end
    if (recall) for (int i = 1; i <= 4; i++) begin mVol[i] = mNv[i]; kVol[i] = kNv[i]; end
    if (ok && a >= 1 && a <= 4) begin
      mVol[a] = d; kVol[a] = 1;
      if (persistNow) begin mNv[a] = d; kNv[a] = 1; end
    end
    if (ok && a == 0) mR0 = d;
    if (ok && a == 5) mR5 = d;
    mPwrQ = p;
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks + 1);
    $finish;
  end

  initial begin
    for (int i = 1; i <= 4; i++) begin kNv[i] = 0; mNv[i] = 0; end
    rstN = 0; pwrUp = 1; wrProtN = 1; addr = 0; wrData = 0; wrEn = 0; rdEn = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ctrl0Out", {24'd0, ctrl0Out}, 32'd0);
    chk("R1", "ctrl5Out", {24'd0, ctrl5Out}, 32'd0);
    chk("R1", "cfgVol", cfgVol, 32'd0);
    chk("R1", "rdData", {24'd0, rdData}, 32'd0);
    mR0 = 0; mR5 = 0; mRd = 0; kRd = 1; mPwrQ = 0;
    for (int i = 1; i <= 4; i++) begin mVol[i] = 0; kVol[i] = 1; end
    rstN = 1;
    step(0, 0, 1, 1, 0, 8'h00, "R1");
    step(0, 0, 1, 1, 0, 8'h00, "R2");
    step(0, 0, 0, 1, 0, 8'h00, "R2");
    // persist on, fill every backing copy
    step(1, 0, 0, 1, 0, 8'h80, "R5");
    for (int i = 1; i <= 4; i++) step(1, 0, 0, 1, i, 8'(8'h11 * i + 3), "R3");
    for (int i = 1; i <= 4; i++) step(0, 1, 0, 1, i, 8'h00, "R7");
    // persist off: working copy only
    step(1, 0, 0, 1, 0, 8'h00, "R3");
    step(1, 0, 0, 1, 2, 8'h5A, "R4");
    step(0, 1, 0, 1, 2, 8'h00, "R4");
    step(1, 0, 0, 1, 5, 8'h33, "R5");
    step(1, 0, 0, 1, 3, 8'hC3, "R4");
    step(0, 0, 1, 1, 0, 8'h00, "R2");
    step(0, 0, 0, 1, 0, 8'h00, "R2");
    // write protect
    step(1, 0, 0, 1, 1, 8'h77, "R6");
    step(1, 0, 0, 0, 5, 8'h99, "R6");
    step(1, 0, 0, 0, 0, 8'h80, "R6");
    step(1, 0, 0, 0, 1, 8'h01, "R6");
    step(0, 1, 0, 1, 5, 8'h00, "R6");
    step(0, 1, 0, 1, 0, 8'h00, "R6");
    // out-of-range addresses
    step(1, 0, 0, 1, 6, 8'hEE, "R8");
    step(1, 0, 0, 1, 7, 8'hDD, "R8");
    step(0, 1, 0, 1, 6, 8'h00, "R8");
    step(0, 1, 0, 1, 7, 8'h00, "R8");
    // release coinciding with a write
    step(1, 0, 0, 1, 2, 8'h3C, "R9");
    step(0, 0, 1, 1, 0, 8'h00, "R9");
    step(1, 0, 0, 1, 1, 8'hA5, "R9");
    // reload decision uses the persist bit held before the write
    step(1, 0, 0, 1, 4, 8'h44, "R5");
    step(1, 0, 0, 1, 0, 8'h80, "R5");
    step(0, 1, 0, 1, 4, 8'h00, "R5");
    // sweep over addresses, data, modes, protect and power pulses
    for (int n = 0; n < 4000; n++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           (n % 97) < 2, ($urandom_range(0, 4) != 0),
           int'($urandom_range(0, 7)), 8'($urandom_range(0, 255)),
           "R3/R4/R5/R6/R9");
    end
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule